// File: doc/BRIEF.md
# Single-Wire Debug Bit Reader

This block is the host-side engine that fetches one data bit from a target over a shared, open-drain, single-wire debug line. A read request makes the host pull the line low, which opens a bit time. The host then lets go of the line, and the target either holds it low to send a 0 or leaves it high to send a 1. At a fixed point in the bit time the host samples the line and returns the bit with a one-clock done strobe.

All timing is counted in target clock cycles. A programmable divider makes one target cycle equal to `clk_div + 1` host clocks. The low-hold length can be set per bit, and it is clamped to a window so that the line is always released before the target sends its high speed-up pulse. The line input passes through a two-flop synchroniser, because the target is asynchronous to the host. The host itself only ever enables a low drive and never drives the line high.

Top module: `dbg_bit_reader`

## Requirements
- R1: After reset, `rd_busy`, `rd_done` and `dbg_drive_low` are all 0.
- R2: When `rd_req` is seen high while the block is idle, `rd_busy` and `dbg_drive_low` are both high one clock later.
- R3: `dbg_drive_low` stays high for exactly H×D host clocks. H is the low-hold count in target cycles, and D = `clk_div`+1.
- R4: H is `hold_cyc` clamped to the range 2..5. A value below 2 gives 2 and a value above 5 gives 5.
- R5: `rd_done` rises 10×D clocks after the request is accepted. At that point `rd_bit` is 1 if the synchronised line was high and 0 if it was low.
- R6: `rd_done` is high for exactly one clock per accepted request.
- R7: `rd_busy` stays high for 16×D clocks. A request made in the first idle cycle after that is accepted.
- R8: A request made while `rd_busy` is high is ignored: it produces no extra done and does not lengthen the busy period.
- R9: The line is released before the sample point: `dbg_drive_low` is never high while `rd_done` is high.
- R10: `clk_div` and `hold_cyc` are captured when a request is accepted. Changing them during a bit time has no effect on that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Host clocks per target cycle, minus one |
| hold_cyc | input | 3 | Requested low-hold length in target cycles |
| rd_req | input | 1 | Start a bit read |
| rd_busy | output | 1 | A bit time is in progress |
| rd_done | output | 1 | One-clock strobe: the bit has been sampled |
| rd_bit | output | 1 | Value of the received bit |
| dbg_drive_low | output | 1 | Enables the open-drain low drive on the line |
| dbg_pin_in | input | 1 | Sensed level of the debug line |

## Verification
Every result is due a fixed number of host clocks after the request is accepted. The drive enable rises after 1 clock and falls after H×D clocks. Done and the bit are due after 10×D clocks, and busy falls after 16×D clocks. The driver computes each due cycle from D and the clamped H, and pushes the expected bit and its due cycle into a queue. The monitor compares each done against the head of the queue, using the absolute cycle count sampled on the falling clock edge, and it flags any done that was not expected. Pulse lengths are measured by counting falling edges while a signal is high.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_WAIT,
    ST_GAP
  } dbr_state_e;
endpackage

// File: rtl/dbr_sync2.sv
module dbr_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic meta_q;
  logic sync_q;

  // Idle bus level is high, so reset to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= d_in;
      sync_q <= meta_q;
    end
  end

  assign q_out = sync_q;
endmodule

// File: rtl/dbr_tick_gen.sv
module dbr_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    div_d = div_q;
    if (start) div_d = div_in;
  end

  assign tick = run && (cnt_q == div_q);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  // R10: divider ratio is frozen for the duration of a bit time
  p_div_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start) |=> (run -> $stable(div_q)));

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div_q));
endmodule

// File: rtl/dbr_seq.sv
module dbr_seq
  import dbr_pkg::*;
#(
  parameter int HOLD_W     = 3,
  parameter int HOLD_MIN   = 2,
  parameter int HOLD_MAX   = 5,
  parameter int SAMPLE_CYC = 10,
  parameter int BIT_CYC    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [HOLD_W-1:0] hold_in,
  input  logic              tick,
  input  logic              line_s,
  output logic              start,
  output logic              busy,
  output logic              drive_low,
  output logic              done,
  output logic              bit_val
);
  localparam int CNT_W = $clog2(BIT_CYC + 1);

  dbr_state_e        state_q, state_d;
  logic [CNT_W-1:0]  tcnt_q, tcnt_d, tcnt_inc;
  logic [CNT_W-1:0]  hold_q, hold_d;
  logic              drv_q, drv_d;
  logic              done_q, done_d;
  logic              bit_q, bit_d;

  function automatic logic [CNT_W-1:0] clamp_hold(input logic [HOLD_W-1:0] h);
    if (int'(h) < HOLD_MIN)      return CNT_W'(HOLD_MIN);
    else if (int'(h) > HOLD_MAX) return CNT_W'(HOLD_MAX);
    else                         return CNT_W'(h);
  endfunction

  assign start    = (state_q == ST_IDLE) && req;
  assign tcnt_inc = tcnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    hold_d  = hold_q;
    drv_d   = drv_q;
    done_d  = 1'b0;
    bit_d   = bit_q;
    if (state_q != ST_IDLE && tick) tcnt_d = tcnt_inc;
    case (state_q)
      ST_IDLE: if (req) begin
        state_d = ST_LOW;
        tcnt_d  = '0;
        hold_d  = clamp_hold(hold_in);
        drv_d   = 1'b1;
      end
      ST_LOW: if (tick && tcnt_inc == hold_q) begin
        state_d = ST_WAIT;
        drv_d   = 1'b0;
      end
      ST_WAIT: if (tick && tcnt_inc == CNT_W'(SAMPLE_CYC)) begin
        state_d = ST_GAP;
        done_d  = 1'b1;
        bit_d   = line_s;
      end
      ST_GAP: if (tick && tcnt_inc == CNT_W'(BIT_CYC)) begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      hold_q  <= CNT_W'(HOLD_MIN);
      drv_q   <= 1'b0;
      done_q  <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      hold_q  <= hold_d;
      drv_q   <= drv_d;
      done_q  <= done_d;
      bit_q   <= bit_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign drive_low = drv_q;
  assign done      = done_q;
  assign bit_val   = bit_q;

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req) |=> (busy && drive_low));
  p_release_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_low) |-> (tcnt_q >= CNT_W'(HOLD_MIN) && tcnt_q <= CNT_W'(HOLD_MAX)));
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_released_at_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !drive_low);
  p_drive_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> busy);
  p_done_in_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && tcnt_q == CNT_W'(SAMPLE_CYC)));
  p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tcnt_q < CNT_W'(BIT_CYC)));
  p_busy_req_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req && state_q != ST_GAP) |=> busy);
endmodule

// File: rtl/dbg_bit_reader.sv
module dbg_bit_reader #(
  parameter int DIV_W      = 8,
  parameter int SAMPLE_CYC = 10,
  parameter int BIT_CYC    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [2:0]       hold_cyc,
  input  logic             rd_req,
  output logic             rd_busy,
  output logic             rd_done,
  output logic             rd_bit,
  output logic             dbg_drive_low,
  input  logic             dbg_pin_in
);
  logic tick;
  logic start;
  logic line_s;

  dbr_sync2 u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (dbg_pin_in),
    .q_out (line_s)
  );

  dbr_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .run    (rd_busy),
    .div_in (clk_div),
    .tick   (tick)
  );

  dbr_seq #(
    .HOLD_W     (3),
    .HOLD_MIN   (2),
    .HOLD_MAX   (5),
    .SAMPLE_CYC (SAMPLE_CYC),
    .BIT_CYC    (BIT_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (rd_req),
    .hold_in   (hold_cyc),
    .tick      (tick),
    .line_s    (line_s),
    .start     (start),
    .busy      (rd_busy),
    .drive_low (dbg_drive_low),
    .done      (rd_done),
    .bit_val   (rd_bit)
  );
endmodule

// File: tb/dbg_bit_reader_tb_top.sv
module dbg_bit_reader_tb_top;
  logic       clk;
  logic       rst_n;
  logic [7:0] clk_div;
  logic [2:0] hold_cyc;
  logic       rd_req;
  logic       rd_busy, rd_done, rd_bit, dbg_drive_low;
  logic       dbg_pin_in;

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;

  typedef struct { logic v; longint due; } exp_t;
  exp_t exp_q[$];

  // Target model: pulls the line low for 13 target cycles when sending a 0.
  logic tgt_zero;
  int   cur_d;
  int   tgt_cnt;
  logic drv_prev;
  logic tgt_pull;

  dbg_bit_reader dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .clk_div       (clk_div),
    .hold_cyc      (hold_cyc),
    .rd_req        (rd_req),
    .rd_busy       (rd_busy),
    .rd_done       (rd_done),
    .rd_bit        (rd_bit),
    .dbg_drive_low (dbg_drive_low),
    .dbg_pin_in    (dbg_pin_in)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    drv_prev <= dbg_drive_low;
    if (dbg_drive_low && !drv_prev) tgt_cnt <= 13 * cur_d;
    else if (tgt_cnt > 0)           tgt_cnt <= tgt_cnt - 1;
  end
  assign tgt_pull   = tgt_zero && (tgt_cnt != 0);
  assign dbg_pin_in = !(dbg_drive_low || tgt_pull);

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Monitor: pop the expected item when done appears.
  always @(negedge clk) begin
    if (rst_n && rd_done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cyc == e.due, "R5 done cycle", cyc, e.due);
        check(rd_bit == e.v, "R5 bit value", rd_bit, e.v);
      end
    end
  end

  task automatic run_bit(input int div, input int hold_in, input bit val,
                         input int hexp, input bit poke);
    int d;
    int n;
    exp_t e;
    d = div + 1;
    @(negedge clk);
    clk_div  = 8'(div);
    hold_cyc = 3'(hold_in);
    tgt_zero = !val;
    cur_d    = d;
    rd_req   = 1'b1;
    e.v   = val;
    e.due = cyc + 1 + 10 * d;
    exp_q.push_back(e);
    @(negedge clk);
    rd_req = 1'b0;
    check(rd_busy && dbg_drive_low, "R2 accept", {rd_busy, dbg_drive_low}, 3);
    n = 0;
    while (dbg_drive_low) begin
      n++;
      if (poke && n == 2) begin
        rd_req = 1'b1;
        clk_div = 8'(div + 3);
        hold_cyc = 3'd5;
      end else begin
        rd_req = 1'b0;
      end
      @(negedge clk);
    end
    rd_req = 1'b0;
    check(n == hexp * d, "R3/R4 low hold length", n, hexp * d);
    while (rd_busy) begin
      n++;
      if (poke && n == 12 * d) rd_req = 1'b1;
      else                     rd_req = 1'b0;
      @(negedge clk);
    end
    rd_req = 1'b0;
    check(n == 16 * d, "R7 busy length (R8 R10 when poked)", n, 16 * d);
    check(exp_q.size() == 0, "R6 one done per request", exp_q.size(), 0);
  endtask

  initial begin
    int w;
    w = 0;
    while (w < 100000) begin
      @(posedge clk);
      w++;
    end
    check(1'b0, "watchdog", w, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    rd_req   = 1'b0;
    clk_div  = 8'd0;
    hold_cyc = 3'd4;
    tgt_zero = 1'b0;
    cur_d    = 1;
    tgt_cnt  = 0;
    drv_prev = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!rd_busy && !rd_done && !dbg_drive_low, "R1 reset outputs",
          {rd_busy, rd_done, dbg_drive_low}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!rd_busy && !dbg_drive_low, "R1 idle after reset", {rd_busy, dbg_drive_low}, 0);

    run_bit(0, 4, 1'b1, 4, 1'b0);   // R5 bit 1, div 1
    run_bit(0, 4, 1'b0, 4, 1'b0);   // R5 bit 0
    run_bit(2, 2, 1'b0, 2, 1'b0);   // R3 divider 3
    run_bit(1, 0, 1'b1, 2, 1'b0);   // R4 clamp low
    run_bit(1, 7, 1'b0, 5, 1'b0);   // R4 clamp high, R9
    run_bit(3, 3, 1'b1, 3, 1'b1);   // R8 R10 poke while busy
    // R7: immediate back-to-back request is accepted
    run_bit(0, 5, 1'b0, 5, 1'b0);
    run_bit(4, 4, 1'b1, 4, 1'b0);

    repeat (5) @(negedge clk);
    check(!rd_busy && !rd_done, "R8 no late activity", {rd_busy, rd_done}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule